// File: doc/BRIEF.md
# Multi-Window Address Translation Unit

This block maps request addresses from an on-chip memory-mapped bus onto a remote address space. It holds a small set of independent windows. Each window has a lower bound, an upper bound and a replacement base, and all three are loaded through a single-cycle configuration write port. Every incoming request address is compared with all windows at once. When an address falls inside a window, the bits above the window's offset field are swapped for that window's replacement base. The offset bits pass through unchanged.

The response comes out one clock after the request. It carries the translated address, a hit flag, the index of the window that matched, a miss strobe, and a flag that tells the remote side whether it needs the long (64-bit) address form or whether the short (32-bit) form is enough. Each window's configuration is also checked all the time, and two flag vectors report windows whose bounds are unusable or whose replacement base is badly aligned. Packet building and link handshakes belong to other blocks.

Top module: `multi_window_atu`

## Requirements
- R1: For a request that hits a window, the response address is the window's replacement base with its offset field cleared, OR'd with the offset field of the request address. `rsp_valid` is high exactly one cycle after `req_valid`.
- R2: A window covers the range from its lower bound to its upper bound, inclusive. Its size is upper minus lower plus one, and that size must be a power of two. The offset field is the low log2(size) bits.
- R3: When several usable windows match, the one with the lowest index is reported in `rsp_win` and used for the translation.
- R4: A valid request that matches no usable window gives `rsp_hit`=0, `rsp_addr`=0, `rsp_win`=0 and `rsp_wide`=0, with `rsp_miss`=1 for that one response cycle.
- R5: A window whose replacement base has any nonzero bit inside its offset field raises its bit in `win_xlat_bad` one cycle after the write. While the flag is set, that window never hits.
- R6: A window raises its bit in `win_cfg_bad` and never hits if any of these holds: upper < lower, the size is not a power of two, or the lower bound is not a multiple of the size. After reset every window has lower = all ones and upper = 0, so every window is flagged.
- R7: For a hit, `rsp_wide` is 1 exactly when bits 63..32 of `rsp_addr` are not all zero. Otherwise it is 0, which selects the 32-bit form.
- R8: A configuration write with `cfg_we`=1 updates window `cfg_win` at the next edge. The `cfg_field` codes are 0 for the lower bound, 1 for the upper bound and 2 for the replacement base. Field code 3, or a window index of NUM_WIN or more, is ignored.
- R9: A synchronous reset clears all response outputs. When `req_valid` is low, the next cycle shows all response outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_win | input | 2 | Window index for the write |
| cfg_field | input | 2 | 0 lower bound, 1 upper bound, 2 replacement base |
| cfg_data | input | 64 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr | output | 64 | Translated address, zero on a miss |
| rsp_hit | output | 1 | A usable window matched |
| rsp_win | output | 2 | Index of the matched window |
| rsp_wide | output | 1 | Translated address needs the 64-bit form |
| rsp_miss | output | 1 | Valid request matched no window |
| win_cfg_bad | output | 3 | Per-window bounds fault |
| win_xlat_bad | output | 3 | Per-window replacement base fault |

## Verification
The bench uses the default parameters: three windows, 64-bit addresses, and the short form being 32 bits wide. With three windows the index field is two bits wide, so index 3 can be written but names no window. That makes the ignored-write path reachable. Three windows are also enough to build an overlap between two of them while a third sits at the very top of the 32-bit space. The 32-bit short form splits the 64-bit result in the middle, so one replacement base with a nonzero upper half exercises the switch to the long form.

// File: rtl/atu_pkg.sv
package atu_pkg;
   typedef enum logic [1:0] {
      FLD_LOWER = 2'd0,
      FLD_UPPER = 2'd1,
      FLD_XBASE = 2'd2,
      FLD_NONE  = 2'd3
   } atu_field_e;
endpackage

// File: rtl/atu_window.sv
module atu_window #(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 2,
   parameter int IDX    = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_win,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              hit,
   output logic [ADDR_W-1:0] xaddr,
   output logic              bad_cfg,
   output logic              bad_xlat
);
   import atu_pkg::*;

   logic [ADDR_W-1:0] lower_q, upper_q, xbase_q;
   logic [ADDR_W-1:0] mask;
   logic              sel;

   assign sel = cfg_we && (cfg_win == IDX_W'(IDX));

   always_ff @(posedge clk) begin
      if (rst) begin
         lower_q <= '1;
         upper_q <= '0;
         xbase_q <= '0;
      end else if (sel) begin
         case (atu_field_e'(cfg_field))
            FLD_LOWER: lower_q <= cfg_data;
            FLD_UPPER: upper_q <= cfg_data;
            FLD_XBASE: xbase_q <= cfg_data;
            default:   ;
         endcase
      end
   end

   always_comb begin
      mask     = upper_q - lower_q;
      bad_cfg  = (upper_q < lower_q)
               || ((mask & (mask + 1'b1)) != '0)
               || ((lower_q & mask) != '0);
      bad_xlat = (xbase_q & mask) != '0;
      hit      = !bad_cfg && !bad_xlat && ((req_addr & ~mask) == lower_q);
      xaddr    = (xbase_q & ~mask) | (req_addr & mask);
   end

   // R2: a reported hit lies inside the inclusive bounds
   p_hit_in_range_r2: assert property (@(posedge clk) disable iff (rst)
      hit |-> (req_addr >= lower_q) && (req_addr <= upper_q));

   // R6: a window with unusable bounds never matches
   p_bad_no_hit_r6: assert property (@(posedge clk) disable iff (rst)
      (upper_q < lower_q) |-> !hit);
endmodule

// File: rtl/atu_pick.sv
module atu_pick #(
   parameter int NUM_WIN = 3,
   parameter int ADDR_W  = 64,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_WIN-1:0] hit_vec,
   input  logic [ADDR_W-1:0]  xaddr [NUM_WIN],
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic [ADDR_W-1:0]  addr
);
   always_comb begin
      any  = 1'b0;
      idx  = '0;
      addr = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any  = 1'b1;
            idx  = IDX_W'(i);
            addr = xaddr[i];
         end
      end
   end

   // R3: the chosen window always matched
   always_comb begin
      if (any) a_pick_hit_r3: assert (hit_vec[idx]);
   end
endmodule

// File: rtl/multi_window_atu.sv
module multi_window_atu #(
   parameter int NUM_WIN  = 3,
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32,
   localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_win,
   input  logic [1:0]         cfg_field,
   input  logic [ADDR_W-1:0]  cfg_data,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_valid,
   output logic [ADDR_W-1:0]  rsp_addr,
   output logic               rsp_hit,
   output logic [IDX_W-1:0]   rsp_win,
   output logic               rsp_wide,
   output logic               rsp_miss,
   output logic [NUM_WIN-1:0] win_cfg_bad,
   output logic [NUM_WIN-1:0] win_xlat_bad
);
   if (NUM_WIN < 1) begin : g_chk_num
      $error("NUM_WIN must be at least 1");
   end
   if (NARROW_W >= ADDR_W || NARROW_W < 1) begin : g_chk_narrow
      $error("NARROW_W must lie between 1 and ADDR_W-1");
   end

   logic [NUM_WIN-1:0] hit_vec;
   logic [ADDR_W-1:0]  xaddr [NUM_WIN];
   logic               any;
   logic [IDX_W-1:0]   idx;
   logic [ADDR_W-1:0]  pick_addr;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      atu_window #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX(w)) u_win (
         .clk      (clk),
         .rst      (rst),
         .cfg_we   (cfg_we),
         .cfg_win  (cfg_win),
         .cfg_field(cfg_field),
         .cfg_data (cfg_data),
         .req_addr (req_addr),
         .hit      (hit_vec[w]),
         .xaddr    (xaddr[w]),
         .bad_cfg  (win_cfg_bad[w]),
         .bad_xlat (win_xlat_bad[w])
      );
   end

   atu_pick #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
      .hit_vec(hit_vec),
      .xaddr  (xaddr),
      .any    (any),
      .idx    (idx),
      .addr   (pick_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_hit   <= 1'b0;
         rsp_win   <= '0;
         rsp_wide  <= 1'b0;
         rsp_miss  <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any;
         rsp_miss  <= req_valid && !any;
         rsp_win   <= (req_valid && any) ? idx : '0;
         rsp_addr  <= (req_valid && any) ? pick_addr : '0;
         rsp_wide  <= req_valid && any && (pick_addr[ADDR_W-1:NARROW_W] != '0);
      end
   end

   p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid);
   p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && rsp_addr == '0);
   p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
      rsp_miss |-> rsp_valid && !rsp_hit && rsp_addr == '0 && !rsp_wide);
   p_wide_form_r7: assert property (@(posedge clk) disable iff (rst)
      rsp_hit |-> rsp_wide == (rsp_addr[ADDR_W-1:NARROW_W] != '0));
   p_flagged_no_hit_r5: assert property (@(posedge clk) disable iff (rst)
      rsp_hit |-> ((($past(win_cfg_bad | win_xlat_bad)) >> rsp_win) & NUM_WIN'(1)) == '0);
endmodule

// File: tb/multi_window_atu_bench.sv
module multi_window_atu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 3;
   localparam int AW = 64;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_win = '0;
   logic [1:0]    cfg_field = '0;
   logic [AW-1:0] cfg_data = '0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_hit, rsp_wide, rsp_miss;
   logic [AW-1:0] rsp_addr;
   logic [1:0]    rsp_win;
   logic [NW-1:0] win_cfg_bad, win_xlat_bad;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   multi_window_atu u_multi_window_atu (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
      .cfg_field(cfg_field), .cfg_data(cfg_data), .req_valid(req_valid),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
      .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_wide(rsp_wide),
      .rsp_miss(rsp_miss), .win_cfg_bad(win_cfg_bad), .win_xlat_bad(win_xlat_bad)
   );

   task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] w, input logic [1:0] f, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_win = w; cfg_field = f; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic win_set(input logic [1:0] w, input logic [AW-1:0] lo, input logic [AW-1:0] hi, input logic [AW-1:0] xb);
      wr(w, 2'd0, lo);
      wr(w, 2'd1, hi);
      wr(w, 2'd2, xb);
   endtask

   // drive a request, sample the registered response at the next negedge
   task automatic req(input logic [AW-1:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_hit(input string tag, input logic [AW-1:0] a, input logic [1:0] w,
                             input logic [AW-1:0] exp, input bit wide);
      req(a);
      chk(rsp_valid && rsp_hit && !rsp_miss, {tag, " hit"}, {60'd0, rsp_valid, rsp_hit, rsp_miss, 1'b0}, 64'hC);
      chk(rsp_addr == exp, {tag, " addr"}, rsp_addr, exp);
      chk(rsp_win == w, {tag, " win"}, 64'(rsp_win), 64'(w));
      chk(rsp_wide == wide, {tag, " wide"}, 64'(rsp_wide), 64'(wide));
   endtask

   task automatic expect_miss(input string tag, input logic [AW-1:0] a);
      req(a);
      chk(rsp_valid && !rsp_hit && rsp_miss && rsp_addr == '0 && rsp_win == '0 && !rsp_wide,
          {tag, " miss"}, rsp_addr, 64'd0);
   endtask

   task automatic t_reset;
      chk(!rsp_valid && !rsp_hit && !rsp_miss && rsp_addr == '0, "R9 reset outputs", rsp_addr, 64'd0);
      chk(win_cfg_bad == 3'b111, "R6 reset windows flagged", 64'(win_cfg_bad), 64'h7);
      expect_miss("R6 reset no window", 64'h0);
      @(negedge clk);
      chk(!rsp_valid && !rsp_miss, "R9 idle clears", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_basic;
      win_set(2'd0, 64'h1234_0000, 64'h1234_FFFF, 64'h5671_0000);
      win_set(2'd1, 64'hABCD_E000, 64'hABCD_FFFF, 64'hFEDC_0000);
      win_set(2'd2, 64'hFE00_0000, 64'hFFFF_FFFF, 64'h4000_0000);
      chk(win_cfg_bad == '0 && win_xlat_bad == '0, "R8 config accepted", 64'({win_cfg_bad, win_xlat_bad}), 64'd0);
      expect_hit("R1 win0 64K", 64'h1234_0ABC, 2'd0, 64'h5671_0ABC, 1'b0);
      expect_hit("R1 win1 8K", 64'hABCD_F123, 2'd1, 64'hFEDC_1123, 1'b0);
      expect_hit("R2 win2 32M", 64'hFFFE_DCBA, 2'd2, 64'h41FE_DCBA, 1'b0);
      expect_hit("R2 win1 lower edge", 64'hABCD_E000, 2'd1, 64'hFEDC_0000, 1'b0);
      expect_hit("R2 win0 upper edge", 64'h1234_FFFF, 2'd0, 64'h5671_FFFF, 1'b0);
      expect_miss("R4 just above win0", 64'h1235_0000);
      expect_miss("R4 just below win1", 64'hABCD_DFFF);
      expect_miss("R4 above 32 bits", 64'h1_FFFF_FFFF);
   endtask

   task automatic t_wide;
      wr(2'd0, 2'd2, 64'h0000_0001_5671_0000);
      expect_hit("R7 wide form", 64'h1234_0ABC, 2'd0, 64'h0000_0001_5671_0ABC, 1'b1);
      wr(2'd0, 2'd2, 64'h5671_0000);
      expect_hit("R7 narrow form again", 64'h1234_0ABC, 2'd0, 64'h5671_0ABC, 1'b0);
   endtask

   task automatic t_priority;
      win_set(2'd1, 64'h1234_0000, 64'h1234_1FFF, 64'hFEDC_0000);
      expect_hit("R3 lowest index wins", 64'h1234_0ABC, 2'd0, 64'h5671_0ABC, 1'b0);
      wr(2'd0, 2'd2, 64'h5671_0001);
      chk(win_xlat_bad == 3'b001, "R5 bad base flagged", 64'(win_xlat_bad), 64'h1);
      expect_hit("R5 flagged window skipped", 64'h1234_0ABC, 2'd1, 64'hFEDC_0ABC, 1'b0);
      wr(2'd0, 2'd2, 64'h5671_0000);
      chk(win_xlat_bad == 3'b000, "R5 flag clears", 64'(win_xlat_bad), 64'h0);
   endtask

   task automatic t_misconfig;
      win_set(2'd2, 64'hFE00_1000, 64'hFF00_0FFF, 64'h4000_0000);
      chk(win_cfg_bad == 3'b100, "R6 misaligned lower", 64'(win_cfg_bad), 64'h4);
      expect_miss("R6 misaligned no hit", 64'hFE80_0000);
      win_set(2'd2, 64'hFE00_0000, 64'hFFFF_FFFE, 64'h4000_0000);
      chk(win_cfg_bad == 3'b100, "R6 size not power of two", 64'(win_cfg_bad), 64'h4);
      expect_miss("R6 odd size no hit", 64'hFE80_0000);
      win_set(2'd2, 64'hFE00_0000, 64'hFFFF_FFFF, 64'h4000_0000);
      chk(win_cfg_bad == 3'b000, "R6 restored", 64'(win_cfg_bad), 64'h0);
   endtask

   task automatic t_ignored;
      wr(2'd3, 2'd0, 64'h1234_0001);
      wr(2'd3, 2'd2, 64'h5671_0001);
      wr(2'd0, 2'd3, 64'hFFFF_FFFF);
      chk(win_cfg_bad == '0 && win_xlat_bad == '0, "R8 ignored writes flags", 64'({win_cfg_bad, win_xlat_bad}), 64'd0);
      expect_hit("R8 ignored writes win0", 64'h1234_0ABC, 2'd0, 64'h5671_0ABC, 1'b0);
      expect_hit("R8 ignored writes win2", 64'hFFFE_DCBA, 2'd2, 64'h41FE_DCBA, 1'b0);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 64'h1234_0010;
      @(negedge clk);
      chk(rsp_valid && rsp_addr == 64'h5671_0010, "R1 first of pair", rsp_addr, 64'h5671_0010);
      req_addr = 64'h0000_0042;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid && rsp_miss && rsp_addr == '0, "R4 second of pair", rsp_addr, 64'd0);
      @(negedge clk);
      chk(!rsp_valid && !rsp_miss, "R9 after pair", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_basic();
      t_wide();
      t_priority();
      t_misconfig();
      t_ignored();
      t_back_to_back();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule